// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, cycle by cycle, which of several hardware thread contexts feeds the next instruction group into a pipeline. It holds one program counter register per thread. Moving from one thread to another therefore costs nothing: no context is saved or restored. Each thread reports a ready flag. The block picks a thread in one of two policies, chosen by a mode pin:

- **Interleaved policy:** it rotates to a different ready thread on every issue.
- **Run-until-blocked policy:** it stays on one thread until that thread stops being ready.

The chosen group goes out on a valid/ready stream:

- `issue_valid` is high whenever some thread is ready.
- The group counts as accepted only in a cycle where `issue_valid` and `issue_ready` are both high.
- While `issue_ready` is low, no thread state changes. The offer can still change if the ready flags, the mode or a redirect change.

An accepted group holds `ISSUE_W` instructions, and all of them belong to the one selected thread. A per-thread redirect loads a new target into that thread's counter, for example after a taken branch.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset every thread counter equals `RESET_PC`. The first offered group comes from thread 0 when thread 0 is ready.
- R2: In interleaved mode (`mode_sel`=0), the search for the next thread starts at the thread after the last accepted one and wraps modulo `NTHR`. The exception is the first issue after reset, whose search starts at thread 0.
- R3: A thread whose `thr_ready` bit is 0 is never offered. The search passes over it to the next ready thread.
- R4: In run-until-blocked mode (`mode_sel`=1), the last accepted thread is offered again on every cycle in which it is still ready.
- R5: In run-until-blocked mode, when the last accepted thread is not ready, the offer moves to the first ready thread after it, in wrapping order.
- R6: When no thread is ready, `issue_valid` is 0. Offering resumes in the first cycle in which any thread is ready.
- R7: In an accepted cycle without a redirect for the selected thread, that thread's counter advances by `ISSUE_W*INSTR_BYTES` on the next cycle.
- R8: When `redir_valid[t]` is 1, thread t's counter takes `redir_pc` slice t on the next edge. Slice t is bits `t*PC_W` upward. The redirect applies whether or not thread t is accepted, and it overrides the advance.
- R9: While `issue_ready` is 0, neither any counter nor the last-accepted thread changes.
- R10: Lane i of `issue_lane_pc` (bits `i*PC_W` upward) equals `issue_pc + i*INSTR_BYTES`. Every lane belongs to thread `issue_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = interleaved, 1 = run-until-blocked |
| thr_ready | input | NTHR | Per-thread ready flag |
| redir_valid | input | NTHR | Per-thread redirect strobe |
| redir_pc | input | NTHR*PC_W | Per-thread redirect targets, thread t at bits t*PC_W |
| issue_ready | input | 1 | Downstream accepts the offered group |
| issue_valid | output | 1 | A group is offered |
| issue_tid | output | TID_W | Thread of the offered group |
| issue_pc | output | PC_W | Counter of the offered thread |
| issue_lane_pc | output | ISSUE_W*PC_W | Address of each lane of the group |

## Verification
The offer outputs depend combinationally on the current ready flags, mode and state, so they are due in the same cycle as the stimulus. The bench drives inputs just after the falling edge and compares the outputs one time unit later. State updates take effect one edge later: the counter advance, a redirect, and the new last-accepted thread. The bench reference model applies them just after each rising edge, so the next cycle's expected values already include them. The checker properties use a one-cycle `|=>` for the same reason.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic {
    SEL_INTERLEAVE = 1'b0,
    SEL_RUN_BLOCK  = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/tis_rr_pick.sv
// Wrapping priority search: first requester at or after start_idx.
module tis_rr_pick #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic [NTHR-1:0]  req,
  input  logic [TID_W-1:0] start_idx,
  output logic [TID_W-1:0] grant,
  output logic             found
);
  always_comb begin
    found = 1'b0;
    grant = start_idx;
    for (int k = 0; k < NTHR; k++) begin
      logic [TID_W:0]   sum;
      logic [TID_W-1:0] idx;
      sum = {1'b0, start_idx} + (TID_W+1)'(k);
      if (sum >= (TID_W+1)'(NTHR)) sum = sum - (TID_W+1)'(NTHR);
      idx = sum[TID_W-1:0];
      if (!found && req[idx]) begin
        found = 1'b1;
        grant = idx;
      end
    end
  end
endmodule

// File: rtl/tis_ctrl.sv
// Tracks the last accepted thread and derives where the next search begins.
module tis_ctrl
  import tis_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sel_mode_e        mode,
  input  logic             fire,
  input  logic [TID_W-1:0] fire_tid,
  output logic [TID_W-1:0] last_tid,
  output logic [TID_W-1:0] start_idx
);
  logic [TID_W-1:0] last_q;
  logic             fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q  <= '0;
      fresh_q <= 1'b1;
    end else if (fire) begin
      last_q  <= fire_tid;
      fresh_q <= 1'b0;
    end
  end

  always_comb begin
    if (mode == SEL_RUN_BLOCK || fresh_q)
      start_idx = last_q;
    else if (last_q == TID_W'(NTHR-1))
      start_idx = '0;
    else
      start_idx = last_q + TID_W'(1);
  end

  assign last_tid = last_q;
endmodule

// File: rtl/tis_pc_bank.sv
// One program counter per thread; redirect wins over the issue advance.
module tis_pc_bank #(
  parameter int              NTHR     = 4,
  parameter int              TID_W    = 2,
  parameter int              PC_W     = 32,
  parameter int              STEP     = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [TID_W-1:0]     fire_tid,
  input  logic [NTHR-1:0]      redir_valid,
  input  logic [NTHR*PC_W-1:0] redir_pc,
  output logic [NTHR*PC_W-1:0] pcs
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [PC_W-1:0] pc_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        pc_q <= RESET_PC;
      else if (redir_valid[t])
        pc_q <= redir_pc[t*PC_W +: PC_W];
      else if (fire && fire_tid == TID_W'(t))
        pc_q <= pc_q + PC_W'(STEP);
    end
    assign pcs[t*PC_W +: PC_W] = pc_q;
  end
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
  import tis_pkg::*;
#(
  parameter int              NTHR        = 4,
  parameter int              PC_W        = 32,
  parameter int              ISSUE_W     = 2,
  parameter int              INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC    = 'h100,
  localparam int             TID_W       = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_sel,
  input  logic [NTHR-1:0]         thr_ready,
  input  logic [NTHR-1:0]         redir_valid,
  input  logic [NTHR*PC_W-1:0]    redir_pc,
  input  logic                    issue_ready,
  output logic                    issue_valid,
  output logic [TID_W-1:0]        issue_tid,
  output logic [PC_W-1:0]         issue_pc,
  output logic [ISSUE_W*PC_W-1:0] issue_lane_pc
);
  localparam int STEP = ISSUE_W * INSTR_BYTES;

  sel_mode_e           mode;
  logic                fire;
  logic                found;
  logic [TID_W-1:0]    grant;
  logic [TID_W-1:0]    start_idx;
  logic [TID_W-1:0]    last_tid;
  logic [NTHR*PC_W-1:0] pcs;

  assign mode = sel_mode_e'(mode_sel);

  tis_ctrl #(.NTHR(NTHR), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fire(fire), .fire_tid(issue_tid),
    .last_tid(last_tid), .start_idx(start_idx)
  );

  tis_rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
    .req(thr_ready), .start_idx(start_idx), .grant(grant), .found(found)
  );

  tis_pc_bank #(
    .NTHR(NTHR), .TID_W(TID_W), .PC_W(PC_W), .STEP(STEP), .RESET_PC(RESET_PC)
  ) u_pcs (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_tid(issue_tid),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .pcs(pcs)
  );

  assign issue_valid = found;
  assign issue_tid   = found ? grant : last_tid;
  assign fire        = issue_valid && issue_ready;
  assign issue_pc    = pcs[issue_tid*PC_W +: PC_W];

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
    assign issue_lane_pc[i*PC_W +: PC_W] = issue_pc + PC_W'(i*INSTR_BYTES);
  end
endmodule

// File: rtl/tis_chk.sv
module tis_chk #(
  parameter int NTHR        = 4,
  parameter int PC_W        = 32,
  parameter int ISSUE_W     = 2,
  parameter int INSTR_BYTES = 4,
  parameter int TID_W       = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_sel,
  input logic [NTHR-1:0]         thr_ready,
  input logic [NTHR-1:0]         redir_valid,
  input logic                    issue_ready,
  input logic                    issue_valid,
  input logic [TID_W-1:0]        issue_tid,
  input logic [PC_W-1:0]         issue_pc,
  input logic [ISSUE_W*PC_W-1:0] issue_lane_pc
);
  localparam int STEP = ISSUE_W * INSTR_BYTES;
  logic fire, sel_redir;
  assign fire      = issue_valid && issue_ready;
  assign sel_redir = redir_valid[issue_tid];

  // R3
  sel_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> thr_ready[issue_tid]);

  // R6
  idle_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |-> !issue_valid);

  // R2
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_sel) |=>
      ((issue_valid && !mode_sel && $countones(thr_ready) > 1) -> (issue_tid != $past(issue_tid))));

  // R4
  stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_sel) |=>
      ((mode_sel && thr_ready[$past(issue_tid)]) -> (issue_tid == $past(issue_tid))));

  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_sel && !sel_redir) |=>
      ((mode_sel && issue_valid && issue_tid == $past(issue_tid)) ->
        (issue_pc == $past(issue_pc) + PC_W'(STEP))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !sel_redir) |=>
      (($stable(thr_ready) && $stable(mode_sel)) -> ($stable(issue_tid) && $stable(issue_pc))));

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane_chk
    // R10
    lane_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_lane_pc[i*PC_W +: PC_W] == issue_pc + PC_W'(i*INSTR_BYTES)));
  end
endmodule

bind thread_issue_sel tis_chk #(
  .NTHR(NTHR), .PC_W(PC_W), .ISSUE_W(ISSUE_W), .INSTR_BYTES(INSTR_BYTES), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .thr_ready(thr_ready),
  .redir_valid(redir_valid), .issue_ready(issue_ready), .issue_valid(issue_valid),
  .issue_tid(issue_tid), .issue_pc(issue_pc), .issue_lane_pc(issue_lane_pc)
);

// File: tb/sim_thread_issue_sel.sv
`timescale 1ns/1ps
module sim_thread_issue_sel;
  localparam int              NTHR = 4;
  localparam int              PC_W = 32;
  localparam int              ISSUE_W = 2;
  localparam int              INSTR_BYTES = 4;
  localparam logic [PC_W-1:0] RESET_PC = 'h100;
  localparam int              TID_W = 2;
  localparam int              STEP = ISSUE_W * INSTR_BYTES;

  logic clk = 0, rst_n = 0;
  logic mode_d = 0, irdy_d = 1;
  logic [NTHR-1:0] ready_d = '1, rv_d = '0;
  logic [PC_W-1:0] rpc_d [NTHR];
  logic [NTHR*PC_W-1:0] redir_pc;
  logic issue_valid;
  logic [TID_W-1:0] issue_tid;
  logic [PC_W-1:0] issue_pc;
  logic [ISSUE_W*PC_W-1:0] issue_lane_pc;

  always #4 clk = ~clk;

  for (genvar t = 0; t < NTHR; t++) begin : g_rpc
    assign redir_pc[t*PC_W +: PC_W] = rpc_d[t];
  end

  thread_issue_sel #(.NTHR(NTHR), .PC_W(PC_W), .ISSUE_W(ISSUE_W),
                     .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_d), .thr_ready(ready_d),
    .redir_valid(rv_d), .redir_pc(redir_pc), .issue_ready(irdy_d),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
    .issue_lane_pc(issue_lane_pc)
  );

  int checks = 0, failures = 0;
  logic [PC_W-1:0] m_pc [NTHR];
  int m_last;
  bit m_fresh;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected thread, or -1 when nothing is ready.
  function automatic int exp_pick(logic [NTHR-1:0] rdy, logic blk, int last, bit fresh);
    int start = (blk || fresh) ? last : (last + 1) % NTHR;
    for (int k = 0; k < NTHR; k++)
      if (rdy[(start + k) % NTHR]) return (start + k) % NTHR;
    return -1;
  endfunction

  task automatic model_reset();
    for (int t = 0; t < NTHR; t++) m_pc[t] = RESET_PC;
    m_last = 0;
    m_fresh = 1;
  endtask

  // Inputs are already driven after a falling edge; check, then advance.
  task automatic tick(string tag);
    int p;
    bit fire;
    #1;
    p = exp_pick(ready_d, mode_d, m_last, m_fresh);
    check("R6", 64'(issue_valid), 64'(p >= 0));
    if (p >= 0) begin
      check(tag, 64'(issue_tid), 64'(p));
      check(tag, 64'(issue_pc), 64'(m_pc[p]));
      for (int i = 0; i < ISSUE_W; i++)
        check("R10", 64'(issue_lane_pc[i*PC_W +: PC_W]), 64'(m_pc[p] + PC_W'(i*INSTR_BYTES)));
    end
    fire = (p >= 0) && irdy_d;
    @(posedge clk);
    for (int t = 0; t < NTHR; t++) begin
      if (rv_d[t]) m_pc[t] = rpc_d[t];
      else if (fire && t == p) m_pc[t] = m_pc[t] + PC_W'(STEP);
    end
    if (fire) begin m_last = p; m_fresh = 0; end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd2024;
    void'($urandom(seed));
    for (int t = 0; t < NTHR; t++) rpc_d[t] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: first group after reset comes from thread 0 at the reset vector
    tick("R1");
    // R2: interleaved, everyone ready
    for (int n = 0; n < 6; n++) tick("R2");
    // R3: interleaved with blocked threads skipped
    ready_d = 4'b0101; for (int n = 0; n < 4; n++) tick("R3");
    ready_d = 4'b1000; for (int n = 0; n < 2; n++) tick("R3");
    ready_d = 4'b0110; for (int n = 0; n < 3; n++) tick("R3");
    // R4: run-until-blocked stays put
    mode_d = 1; ready_d = '1;
    for (int n = 0; n < 4; n++) tick("R4");
    // R5: current thread blocks, switch to the next ready one
    for (int n = 0; n < 4; n++) begin
      ready_d = ~(NTHR'(1) << m_last);
      tick("R5");
      tick("R4");
    end
    // R6: nobody ready, then resume
    ready_d = '0; for (int n = 0; n < 3; n++) tick("R6");
    ready_d = 4'b0010; tick("R6");
    // R9: back-pressure holds everything
    mode_d = 0; ready_d = '1; irdy_d = 0;
    for (int n = 0; n < 3; n++) tick("R9");
    irdy_d = 1; tick("R9");
    // R8: redirect of the selected thread and of an idle thread
    rv_d = '1;
    for (int t = 0; t < NTHR; t++) rpc_d[t] = 32'h4000 + 32'(t * 32'h100);
    tick("R8");
    rv_d = '0;
    for (int n = 0; n < 4; n++) tick("R8");
    rv_d = 4'b0001; rpc_d[0] = 32'h8000; irdy_d = 0; tick("R8");
    rv_d = '0; irdy_d = 1; for (int n = 0; n < 4; n++) tick("R8");
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 49) == 0) mode_d = ~mode_d;
      ready_d = NTHR'($urandom) | NTHR'($urandom);
      if ($urandom_range(0, 19) == 0) ready_d = '0;
      irdy_d = ($urandom_range(0, 9) < 8);
      rv_d = '0;
      for (int t = 0; t < NTHR; t++) begin
        if ($urandom_range(0, 9) == 0) begin
          rv_d[t] = 1'b1;
          rpc_d[t] = {$urandom} & ~32'h3;
        end
      end
      tick(mode_d ? "R5" : "R2");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule